// File: doc/BRIEF.md
# Shared Pad Power-Clamp Sequencer

This block drives the three isolation controls of an I/O pad group: a core-down signal, an early clamp and a final clamp. Several clients share the pad group. Each client pulses an enable line when it needs the pads and a disable line when it is done. An internal usage count records how many clients hold the pads. Only the enable that takes the count from zero runs the power-up sequence. Only the disable that returns the count to zero runs the power-down sequence. Every other request just moves the count.

Power-up releases the clamp first, then the early clamp, then core-down. Power-down asserts them in the opposite order. A fixed dwell of `DWELL_US` microseconds separates consecutive steps. The microsecond is `CLK_PER_US` system clocks, so one dwell is exactly N = `DWELL_US*CLK_PER_US` cycles. Requests go into a small queue and are handled one at a time whenever no sequence is running. The control pins are plain one-cycle pulses. There is no handshake, so a request that cannot be stored is reported as dropped rather than back-pressured. For software, the three outputs map to bits 31 (core-down), 30 (early clamp) and 29 (clamp) of one control word. A surrounding wrapper may use that mapping.

Top module: `pad_iso_seq`

## Requirements
- R1: After reset, core_down, early_clamp and clamp are all 1 (powered down), the usage count is zero, and busy, unbal_err and req_drop are 0.
- R2: An enable taken from the queue while the count is zero sets the count to 1. It drops clamp at the edge that takes it. It drops early_clamp N cycles later and core_down N cycles after that. A request sampled at an edge with the block idle and the queue empty is taken at the next edge.
- R3: An enable taken while the count is nonzero (and below its maximum) increments the count and changes no output.
- R4: A disable taken while the count is 1 sets the count to 0. It raises core_down at the edge that takes it. It raises early_clamp N cycles later and clamp N cycles after that.
- R5: A disable taken while the count is above 1 decrements the count and changes no output.
- R6: A disable taken while the count is zero pulses unbal_err high for one cycle. It leaves the count and all outputs unchanged.
- R7: busy is 1 whenever a sequence is running or the queue holds a request, and is 0 otherwise. When busy is 0, the three outputs are all equal.
- R8: Requests that arrive while a sequence runs or the queue is nonempty are handled in arrival order. One request is taken per edge once no sequence is running.
- R9: A request that arrives when the queue already holds `QDEPTH` entries is discarded, and req_drop pulses high for one cycle.
- R10: An enable taken while the count is at its maximum (2^`CNT_W`-1) is discarded, req_drop pulses for one cycle, and no output changes.
- R11: An enable and a disable sampled at the same edge cancel. Nothing is queued, and no count, output or flag changes.
- R12: At all times clamp=1 implies early_clamp=1, and early_clamp=1 implies core_down=1. At most one of the three outputs changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | One-cycle enable request from a client |
| dis_req | input | 1 | One-cycle disable request from a client |
| core_down | output | 1 | Core-down isolation control, 1 = asserted |
| early_clamp | output | 1 | Early clamp control, 1 = asserted |
| clamp | output | 1 | Final clamp control, 1 = asserted |
| busy | output | 1 | Sequence running or requests pending |
| unbal_err | output | 1 | One-cycle pulse: disable with zero count |
| req_drop | output | 1 | One-cycle pulse: request lost (queue full or count saturated) |

## Verification
The hardest situation to reach is a full queue whose contents cross a zero-count boundary. A power-down must start from queued requests, and a leftover disable must then hit a zero count. Ordinary traffic empties the queue after each request. The bench starts a power-up and then, during its first dwell, pushes a burst of back-to-back requests. These are one enable, three disables and a fifth request that overflows the queue. It then checks the exact edge at which the power-down begins and the edge at which the trailing unbalanced disable reports. A sweep of one to three nested enable/disable pairs and a count-saturation case covers the remaining count transitions.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_A,
    ST_UP_B,
    ST_DN_A,
    ST_DN_B
  } seq_state_t;

  localparam logic KIND_EN  = 1'b1;
  localparam logic KIND_DIS = 1'b0;
endpackage

// File: rtl/iso_req_queue.sv
module iso_req_queue #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_kind,
  input  logic pop,
  output logic head_kind,
  output logic empty,
  output logic full_drop
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kind_mem;
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  assign empty     = (cnt_q == '0);
  assign push_ok   = push && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok    = pop && !empty;
  assign head_kind = kind_mem[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q      <= '0;
      rd_q      <= '0;
      cnt_q     <= '0;
      kind_mem  <= '0;
      full_drop <= 1'b0;
    end else begin
      full_drop <= push && !push_ok;
      if (push_ok) begin
        kind_mem[wr_q] <= push_kind;
        wr_q           <= next_idx(wr_q);
      end
      if (pop_ok) rd_q <= next_idx(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9: the occupancy never exceeds the queue depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R9: a drop pulse only follows a push into a queue that was full
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_drop |-> $past(push) && ($past(cnt_q) == CNT_W'(DEPTH)));
endmodule

// File: rtl/iso_dwell_timer.sv
module iso_dwell_timer #(
  parameter int CLK_PER_US = 8,
  parameter int DWELL_US   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int US_W = (DWELL_US > 1) ? $clog2(DWELL_US) : 1;

  logic            tick;
  logic [US_W-1:0] us_q;

  generate
    if (CLK_PER_US > 1) begin : g_pre
      localparam int PRE_W = $clog2(CLK_PER_US);
      logic [PRE_W-1:0] pre_q;
      assign tick = (pre_q == PRE_W'(CLK_PER_US - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) pre_q <= '0;
        else if (tick)                pre_q <= '0;
        else                          pre_q <= pre_q + PRE_W'(1);
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign expire = run && tick && (us_q == US_W'(DWELL_US - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire) us_q <= '0;
    else if (tick)                us_q <= us_q + US_W'(1);
  end

  // R2: the microsecond count stays inside one dwell
  p_us_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= US_W'(DWELL_US - 1));
endmodule

// File: rtl/iso_seq_fsm.sv
module iso_seq_fsm
  import iso_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic have_req,
  input  logic head_kind,
  input  logic expire,
  output logic pop,
  output logic in_wait,
  output logic core_down,
  output logic early_clamp,
  output logic clamp,
  output logic unbal_err,
  output logic sat_drop
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_t       st_q;
  logic [CNT_W-1:0] use_q;

  assign pop     = (st_q == ST_IDLE) && have_req;
  assign in_wait = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      use_q       <= '0;
      core_down   <= 1'b1;
      early_clamp <= 1'b1;
      clamp       <= 1'b1;
      unbal_err   <= 1'b0;
      sat_drop    <= 1'b0;
    end else begin
      unbal_err <= 1'b0;
      sat_drop  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (have_req) begin
            if (head_kind == KIND_EN) begin
              if (use_q == CNT_MAX) begin
                sat_drop <= 1'b1;
              end else if (use_q == '0) begin
                use_q <= CNT_ONE;
                clamp <= 1'b0;
                st_q  <= ST_UP_A;
              end else begin
                use_q <= use_q + CNT_ONE;
              end
            end else begin
              if (use_q == '0) begin
                unbal_err <= 1'b1;
              end else if (use_q == CNT_ONE) begin
                use_q     <= '0;
                core_down <= 1'b1;
                st_q      <= ST_DN_A;
              end else begin
                use_q <= use_q - CNT_ONE;
              end
            end
          end
        end
        ST_UP_A: if (expire) begin
          early_clamp <= 1'b0;
          st_q        <= ST_UP_B;
        end
        ST_UP_B: if (expire) begin
          core_down <= 1'b0;
          st_q      <= ST_IDLE;
        end
        ST_DN_A: if (expire) begin
          early_clamp <= 1'b1;
          st_q        <= ST_DN_B;
        end
        ST_DN_B: if (expire) begin
          clamp <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R12: clamp implies early clamp implies core-down
  p_clamp_chain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp |-> early_clamp) and (early_clamp |-> core_down));

  // R12: one output moves per cycle at most
  p_single_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({core_down ^ $past(core_down), early_clamp ^ $past(early_clamp),
                clamp ^ $past(clamp)}) <= 1);

  // R6: an unbalanced disable only happens fully powered down and idle
  p_unbal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unbal_err |-> core_down && early_clamp && clamp && (st_q == ST_IDLE) && (use_q == '0));

  // R10: saturation is only possible while powered up
  p_sat_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_drop |-> !core_down && !clamp && (use_q == CNT_MAX));

  // R2/R4: a nonzero count while idle means powered up, zero means down
  p_count_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> ((use_q == '0) == core_down));
endmodule

// File: rtl/pad_iso_seq.sv
module pad_iso_seq #(
  parameter int CLK_PER_US = 8,
  parameter int DWELL_US   = 100,
  parameter int CNT_W      = 4,
  parameter int QDEPTH     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  output logic core_down,
  output logic early_clamp,
  output logic clamp,
  output logic busy,
  output logic unbal_err,
  output logic req_drop
);
  logic q_empty, q_drop, head_kind, pop, in_wait, expire, sat_drop;
  logic push;

  // opposite requests in the same cycle cancel each other (R11)
  assign push = en_req ^ dis_req;

  iso_req_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_kind (en_req),
    .pop       (pop),
    .head_kind (head_kind),
    .empty     (q_empty),
    .full_drop (q_drop)
  );

  iso_dwell_timer #(.CLK_PER_US(CLK_PER_US), .DWELL_US(DWELL_US)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_wait),
    .expire (expire)
  );

  iso_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .have_req    (!q_empty),
    .head_kind   (head_kind),
    .expire      (expire),
    .pop         (pop),
    .in_wait     (in_wait),
    .core_down   (core_down),
    .early_clamp (early_clamp),
    .clamp       (clamp),
    .unbal_err   (unbal_err),
    .sat_drop    (sat_drop)
  );

  assign busy     = in_wait || !q_empty;
  assign req_drop = q_drop || sat_drop;

  // R7: when not busy the pads are either fully up or fully down
  p_idle_uniform_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (core_down == early_clamp) && (early_clamp == clamp));

  // R11: simultaneous opposite requests never make the block busy by themselves
  p_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && dis_req && !busy) |=> !busy);
endmodule

// File: tb/pad_iso_seq_test.sv
module pad_iso_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 3;
  localparam int DW  = 4;
  localparam int N   = CPU * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0;
  logic dis_req = 1'b0;
  logic core_down, early_clamp, clamp, busy, unbal_err, req_drop;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pad_iso_seq #(.CLK_PER_US(CPU), .DWELL_US(DW), .CNT_W(2), .QDEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .core_down(core_down), .early_clamp(early_clamp), .clamp(clamp),
    .busy(busy), .unbal_err(unbal_err), .req_drop(req_drop)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // {core_down, early_clamp, clamp} and busy
  task automatic chk_out(input string tag, input logic [2:0] outs, input logic bsy);
    chk(tag, {core_down, early_clamp, clamp, busy}, {outs, bsy});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic req(input logic e, input logic d);
    en_req = e;
    dis_req = d;
    @(negedge clk);
    en_req = 1'b0;
    dis_req = 1'b0;
  endtask

  task automatic run_up(input string tag);
    chk_out({tag, " R7 accepted"}, 3'b111, 1'b1);
    step(1);       chk_out({tag, " R2 clamp released"}, 3'b110, 1'b1);
    step(N - 1);   chk_out({tag, " R2 early held"}, 3'b110, 1'b1);
    step(1);       chk_out({tag, " R2 early released"}, 3'b100, 1'b1);
    step(N - 1);   chk_out({tag, " R2 core held"}, 3'b100, 1'b1);
    step(1);       chk_out({tag, " R2 core released"}, 3'b000, 1'b0);
  endtask

  task automatic run_down(input string tag);
    chk_out({tag, " R7 accepted"}, 3'b000, 1'b1);
    step(1);       chk_out({tag, " R4 core asserted"}, 3'b100, 1'b1);
    step(N - 1);   chk_out({tag, " R4 early held"}, 3'b100, 1'b1);
    step(1);       chk_out({tag, " R4 early asserted"}, 3'b110, 1'b1);
    step(N - 1);   chk_out({tag, " R4 clamp held"}, 3'b110, 1'b1);
    step(1);       chk_out({tag, " R4 clamp asserted"}, 3'b111, 1'b0);
  endtask

  task automatic nest_up(input int k);
    for (int i = 0; i < k; i++) begin
      req(1'b1, 1'b0);
      if (i == 0) run_up("nest");
      else begin
        chk_out("R3 queued enable", 3'b000, 1'b1);
        step(1);
        chk_out("R3 extra enable no change", 3'b000, 1'b0);
      end
    end
  endtask

  task automatic nest_down(input int k);
    for (int i = 0; i < k; i++) begin
      req(1'b0, 1'b1);
      if (i == k - 1) run_down("nest");
      else begin
        step(1);
        chk_out("R5 partial disable no change", 3'b000, 1'b0);
      end
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk_out("R1 reset outputs", 3'b111, 1'b0);
    chk("R1 reset flags", {2'b00, unbal_err, req_drop}, 4'b0000);

    // R2/R3/R5/R4 basic
    req(1'b1, 1'b0); run_up("first");
    nest_up(0);
    req(1'b1, 1'b0); chk_out("R3 second enable queued", 3'b000, 1'b1);
    step(1);         chk_out("R3 second enable no change", 3'b000, 1'b0);
    req(1'b0, 1'b1); step(1); chk_out("R5 disable 2->1", 3'b000, 1'b0);
    req(1'b0, 1'b1); run_down("last");

    // R6 unbalanced disable, count must stay zero
    req(1'b0, 1'b1);
    step(1); chk("R6 unbal pulse", {core_down, early_clamp, clamp, unbal_err}, 4'b1111);
    step(1); chk("R6 unbal one cycle", {busy, 2'b00, unbal_err}, 4'b0000);
    req(1'b1, 1'b0); run_up("R6 after unbal");
    req(1'b0, 1'b1); run_down("R6 after unbal");

    // sweep nesting depth
    for (int k = 1; k <= 3; k++) begin
      nest_up(k);
      nest_down(k);
    end

    // R10 saturation at count 3
    nest_up(3);
    req(1'b1, 1'b0);
    step(1); chk("R10 saturated enable dropped", {core_down, early_clamp, clamp, req_drop}, 4'b0001);
    step(1); chk("R10 drop one cycle", {busy, 2'b00, req_drop}, 4'b0000);
    nest_down(3);

    // R8/R9 burst during power-up
    req(1'b1, 1'b0);
    req(1'b1, 1'b0);
    req(1'b0, 1'b1);
    req(1'b0, 1'b1);
    req(1'b0, 1'b1);
    req(1'b1, 1'b0);
    chk("R9 full queue drop", {3'b000, req_drop}, 4'b0001);
    step(2 * N - 4); chk_out("R8 powered up, queue pending", 3'b000, 1'b1);
    step(1);         chk_out("R8 first queued enable", 3'b000, 1'b1);
    step(1);         chk_out("R8 first queued disable", 3'b000, 1'b1);
    step(1);         chk_out("R8 second disable starts down", 3'b100, 1'b1);
    step(2 * N);     chk_out("R8 down complete", 3'b111, 1'b1);
    step(1);         chk("R8 trailing disable unbalanced", {3'b000, unbal_err}, 4'b0001);
    step(1);         chk_out("R8 queue drained", 3'b111, 1'b0);

    // R11 simultaneous requests cancel
    req(1'b1, 1'b1);
    chk_out("R11 cancel not queued", 3'b111, 1'b0);
    step(1); chk("R11 no flags", {1'b0, busy, unbal_err, req_drop}, 4'b0000);
    step(N); chk_out("R11 outputs unchanged", 3'b111, 1'b0);
    req(1'b1, 1'b0); run_up("R11 count still zero");
    req(1'b1, 1'b1); step(2); chk_out("R11 cancel while up", 3'b000, 1'b0);
    req(1'b0, 1'b1); run_down("R11 count still one");

    summary();
  end
endmodule